// File: doc/BRIEF.md
# Floating-Point NaN and Invalid-Case Resolver

This combinational unit sits beside a single-precision add or fused multiply-add datapath. It decides when the arithmetic result must be replaced. For an add it looks at two operand words. For a multiply-add of the form `acc + m1*m2` it looks at three words, plus a flag from the multiplier front end that marks an infinity-times-zero product. When any operand is a NaN, or the product is invalid, it raises an override strobe and supplies the replacement word. It also reports whether the invalid-operation exception applies.

Two NaN-handling policies can be selected at run time:

- **Quieting policy.** Signalling NaNs are converted to quiet NaNs and the invalid flag is raised. NaN operands are ranked with the later operand winning: for an add the second operand wins, and for a multiply-add the accumulator wins, then the second multiplicand.
- **Raw policy.** The first NaN found in operand order is returned unchanged, including its signalling bit. This policy never raises a flag.

In both policies an invalid product with no NaN present yields the canonical quiet NaN. The surrounding pipeline muxes `ovr_result` over its own result whenever `ovr_valid` is high.

The unit has no storage and no handshake. Every output is a pure function of the current inputs.

Top module: `fpnan_resolve`

## Requirements
- R1: When no operand that the selected operation uses is a NaN, and no invalid product applies, `ovr_valid` is 0, `ovr_result` is 0 and `invalid` is 0.
- R2: A word is a NaN exactly when bits 30:23 are all ones and bits 22:0 are nonzero. Bit 22 set means quiet and bit 22 clear means signalling. Infinities and the sign bit do not affect NaN status.
- R3: With `policy_raw`=0 (quieting), a quiet NaN that is selected appears on `ovr_result` bit-for-bit. `invalid` stays 0 unless another rule raises it.
- R4: With `policy_raw`=0, a signalling NaN that is selected appears with bit 22 forced to 1. `invalid` is 1 whenever any used operand is a signalling NaN.
- R5: With `op_fma`=0 (add) and `policy_raw`=0, if both `opnd_x` and `opnd_y` are NaNs, the result derives from `opnd_y`.
- R6: With `op_fma`=0 and `policy_raw`=1 (raw), the first NaN in the order `opnd_x` then `opnd_y` is output unchanged.
- R7: With `op_fma`=1 and `policy_raw`=0, NaN priority is `opnd_acc`, then `opnd_y` (second multiplicand), then `opnd_x` (first multiplicand).
- R8: With `op_fma`=1 and `policy_raw`=1, NaN priority is `opnd_x`, then `opnd_y`, then `opnd_acc`, and the winning word is output unchanged.
- R9: With `op_fma`=1, `prod_inf_zero`=1 and no NaN operand, the output is 0x7fc00000 with `ovr_valid`=1. `invalid` is 1 under the quieting policy and 0 under the raw policy.
- R10: With `op_fma`=1, `prod_inf_zero`=1 and a NaN accumulator, the accumulator is output: quieted under the quieting policy, unchanged under the raw policy. `invalid` is 1 under the quieting policy.
- R11: With `op_fma`=0, `opnd_acc` and `prod_inf_zero` have no effect on any output.
- R12: With `policy_raw`=1, `invalid` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_x | input | 32 | First add operand, or first multiplicand |
| opnd_y | input | 32 | Second add operand, or second multiplicand |
| opnd_acc | input | 32 | Accumulator; used only when `op_fma`=1 |
| op_fma | input | 1 | 0 = two-operand add, 1 = multiply-add |
| policy_raw | input | 1 | 0 = quieting policy, 1 = raw policy |
| prod_inf_zero | input | 1 | Product is infinity times zero (multiply-add only) |
| ovr_valid | output | 1 | Replace the datapath result with `ovr_result` |
| ovr_result | output | 32 | Replacement word; 0 when `ovr_valid` is 0 |
| invalid | output | 1 | Invalid-operation exception |

## Verification
All three outputs are combinational, so each result is due in the same cycle as its stimulus; zero register stages lie between the inputs and the outputs. The bench changes the inputs on the falling clock edge and samples 2 ns later, once the logic has settled and well before the next rising edge. No sample can therefore see a mix of old and new inputs. Directed cases cover each priority order, quieting of both signalling patterns, and the invalid-product paths. Seeded random operands, biased toward NaNs, infinities and zeros, are then compared against a reference function written separately in the bench.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;
  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = FP_W - EXP_W - 1;
  localparam int QBIT  = MAN_W - 1;
  localparam int N_OPND = 3;

  localparam logic [FP_W-1:0] QUIET_MASK  = FP_W'(1) << QBIT;
  localparam logic [FP_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic {OP_ADD = 1'b0, OP_FMA = 1'b1} op_kind_e;
  typedef enum logic {POL_QUIET = 1'b0, POL_RAW = 1'b1} nan_policy_e;

  typedef struct packed {
    logic            is_nan;
    logic            is_snan;
    logic [FP_W-1:0] raw;
  } nan_info_t;
endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
  import fpnan_pkg::*;
(
  input  logic [FP_W-1:0] word,
  output nan_info_t       info
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = word[FP_W-2 -: EXP_W];
  assign man_f = word[MAN_W-1:0];

  always_comb begin
    info.is_nan  = (&exp_f) && (|man_f);
    info.is_snan = info.is_nan && !man_f[QBIT];
    info.raw     = word;
  end
endmodule

// File: rtl/fpnan_prio.sv
module fpnan_prio
  import fpnan_pkg::*;
#(
  parameter int N = N_OPND
) (
  input  nan_info_t       slot [N],
  output logic            found,
  output logic [FP_W-1:0] win_word
);
  // Slot 0 has the highest priority; scan from the lowest so slot 0 lands last.
  always_comb begin
    found    = 1'b0;
    win_word = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (slot[i].is_nan) begin
        found    = 1'b1;
        win_word = slot[i].raw;
      end
    end
  end
endmodule

// File: rtl/fpnan_resolve.sv
module fpnan_resolve
  import fpnan_pkg::*;
(
  input  logic [31:0] opnd_x,
  input  logic [31:0] opnd_y,
  input  logic [31:0] opnd_acc,
  input  logic        op_fma,
  input  logic        policy_raw,
  input  logic        prod_inf_zero,
  output logic        ovr_valid,
  output logic [31:0] ovr_result,
  output logic        invalid
);
  localparam int IDX_X = 0;
  localparam int IDX_Y = 1;
  localparam int IDX_A = 2;

  logic [FP_W-1:0] words [N_OPND];
  nan_info_t       info  [N_OPND];
  nan_info_t       order [N_OPND];
  op_kind_e        kind;
  nan_policy_e     pol;
  logic            any_snan;
  logic            bad_prod;
  logic            found;
  logic [FP_W-1:0] win_word;

  assign words[IDX_X] = opnd_x;
  assign words[IDX_Y] = opnd_y;
  assign words[IDX_A] = opnd_acc;
  assign kind = op_kind_e'(op_fma);
  assign pol  = nan_policy_e'(policy_raw);

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fpnan_classify u_cls (.word(words[g]), .info(info[g]));
  end

  // Priority ordering per operation and policy; unused slots are masked.
  always_comb begin
    unique case ({kind, pol})
      {OP_ADD, POL_QUIET}: begin
        order[0] = info[IDX_Y];
        order[1] = info[IDX_X];
        order[2] = '0;
      end
      {OP_ADD, POL_RAW}: begin
        order[0] = info[IDX_X];
        order[1] = info[IDX_Y];
        order[2] = '0;
      end
      {OP_FMA, POL_QUIET}: begin
        order[0] = info[IDX_A];
        order[1] = info[IDX_Y];
        order[2] = info[IDX_X];
      end
      default: begin
        order[0] = info[IDX_X];
        order[1] = info[IDX_Y];
        order[2] = info[IDX_A];
      end
    endcase
  end

  fpnan_prio #(.N(N_OPND)) u_prio (
    .slot     (order),
    .found    (found),
    .win_word (win_word)
  );

  always_comb begin
    any_snan = 1'b0;
    for (int i = 0; i < N_OPND; i++) any_snan |= order[i].is_snan;
  end

  assign bad_prod = (kind == OP_FMA) && prod_inf_zero;

  always_comb begin
    ovr_valid  = found || bad_prod;
    ovr_result = '0;
    if (found)
      ovr_result = (pol == POL_RAW) ? win_word : (win_word | QUIET_MASK);
    else if (bad_prod)
      ovr_result = DEFAULT_NAN;
    invalid = (pol == POL_QUIET) && (any_snan || bad_prod);
  end
endmodule

// File: rtl/fpnan_resolve_chk.sv
module fpnan_resolve_chk (
  input logic [31:0] opnd_x,
  input logic [31:0] opnd_y,
  input logic [31:0] opnd_acc,
  input logic        op_fma,
  input logic        policy_raw,
  input logic        prod_inf_zero,
  input logic        ovr_valid,
  input logic [31:0] ovr_result,
  input logic        invalid
);
  function automatic logic nan_w(input logic [31:0] w);
    return (w[30:23] == 8'hff) && (w[22:0] != 23'd0);
  endfunction

  logic none_nan;
  assign none_nan = !nan_w(opnd_x) && !nan_w(opnd_y) && !(op_fma && nan_w(opnd_acc));

  always_comb begin
    if (!$isunknown({opnd_x, opnd_y, opnd_acc, op_fma, policy_raw, prod_inf_zero,
                     ovr_valid, ovr_result, invalid})) begin
      AST_IDLE_IS_ZERO: assert (ovr_valid || (ovr_result == 32'd0 && !invalid)); // R1
      AST_NO_CAUSE_NO_OVR: assert (!(none_nan && !(op_fma && prod_inf_zero)) || !ovr_valid); // R1
      AST_QUIET_OUT: assert (!(ovr_valid && !policy_raw) || (ovr_result[30:22] == 9'h1ff)); // R4
      AST_FLAG_NEEDS_OVR: assert (!invalid || ovr_valid); // R4
      AST_RAW_NEVER_FLAGS: assert (!policy_raw || !invalid); // R12
      AST_DEFAULT_NAN: assert (!(op_fma && prod_inf_zero && none_nan) || (ovr_valid && ovr_result == 32'h7fc00000)); // R9
    end
  end
endmodule

bind fpnan_resolve fpnan_resolve_chk u_chk (
  .opnd_x        (opnd_x),
  .opnd_y        (opnd_y),
  .opnd_acc      (opnd_acc),
  .op_fma        (op_fma),
  .policy_raw    (policy_raw),
  .prod_inf_zero (prod_inf_zero),
  .ovr_valid     (ovr_valid),
  .ovr_result    (ovr_result),
  .invalid       (invalid)
);

// File: tb/fpnan_resolve_tb.sv
module fpnan_resolve_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] x = '0, y = '0, acc = '0;
  logic        fma = 1'b0, rawp = 1'b0, piz = 1'b0;
  logic        ovr_valid, invalid;
  logic [31:0] ovr_result;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fpnan_resolve u_dut (
    .opnd_x(x), .opnd_y(y), .opnd_acc(acc), .op_fma(fma), .policy_raw(rawp),
    .prod_inf_zero(piz), .ovr_valid(ovr_valid), .ovr_result(ovr_result), .invalid(invalid)
  );

  function automatic bit is_nan(input logic [31:0] w);
    return (w[30:23] == 8'hff) && (w[22:0] != 0);
  endfunction
  function automatic bit is_sig(input logic [31:0] w);
    return is_nan(w) && !w[22];
  endfunction

  // {valid, invalid, result}
  function automatic logic [33:0] ref_model(input bit f, input bit r, input bit p,
                                            input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] c);
    logic [31:0] cand [3];
    logic [31:0] pick = '0;
    bit hit = 0;
    bit flag;
    int n = f ? 3 : 2;
    if (!f) begin
      cand[0] = r ? a : b; cand[1] = r ? b : a; cand[2] = '0;
    end else begin
      cand[0] = r ? a : c; cand[1] = b; cand[2] = r ? c : a;
    end
    for (int i = 0; i < n; i++)
      if (!hit && is_nan(cand[i])) begin hit = 1; pick = cand[i]; end
    flag = !r && (is_sig(a) || is_sig(b) || (f && is_sig(c)) || (f && p));
    if (hit) return {1'b1, flag, r ? pick : (pick | 32'h0040_0000)};
    if (f && p) return {1'b1, flag, 32'h7fc0_0000};
    return {1'b0, 1'b0, 32'h0};
  endfunction

  task automatic check(input string tag, input logic [33:0] exp_v);
    logic [33:0] act = {ovr_valid, invalid, ovr_result};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: got valid=%0b inv=%0b res=%08h expected valid=%0b inv=%0b res=%08h",
               tag, act[33], act[32], act[31:0], exp_v[33], exp_v[32], exp_v[31:0]);
    end
  endtask

  task automatic apply(input string tag, input bit f, input bit r, input bit p,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic [33:0] exp_v);
    @(negedge clk);
    fma = f; rawp = r; piz = p; x = a; y = b; acc = c;
    #2;
    check(tag, exp_v);
    if (exp_v !== ref_model(f, r, p, a, b, c)) begin
      errors++;
      $display("FAIL %s: reference function disagrees with directed value", tag);
    end
  endtask

  function automatic logic [31:0] rand_opnd();
    logic [31:0] v = $urandom;
    case ($urandom % 6)
      0: v[30:23] = 8'h80;
      1: v[30:0] = 31'h7f80_0000;
      2: v[30:0] = '0;
      3: v[30:22] = 9'h1ff;
      4: begin v[30:23] = 8'hff; v[22] = 1'b0; if (v[21:0] == 0) v[0] = 1'b1; end
      default: ;
    endcase
    return v;
  endfunction

  localparam logic [31:0] ONE = 32'h3f80_0000, PINF = 32'h7f80_0000, ZERO = 32'h0;

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 reset state zero inputs", 34'h0);
    apply("R1 plain add", 0, 0, 0, 32'h3fc0_0000, 32'h3440_0000, 0, 34'h0);
    apply("R2 infinities are not NaN", 0, 0, 0, PINF, 32'hff80_0000, 0, 34'h0);
    apply("R2 negative signalling NaN detected", 0, 1, 0, 32'hff80_0001, ONE, 0, {2'b10, 32'hff80_0001});
    apply("R3 quiet NaN passes", 0, 0, 0, 32'h3fc0_0000, 32'h7fc0_0001, 0, {2'b10, 32'h7fc0_0001});
    apply("R4 signalling quieted", 0, 0, 0, 32'h3fc0_0000, 32'h7f80_0001, 0, {2'b11, 32'h7fc0_0001});
    apply("R5 second NaN wins", 0, 0, 0, 32'h7f80_0001, 32'h7fbf_ffff, 0, {2'b11, 32'h7fff_ffff});
    apply("R5 second NaN wins rev", 0, 0, 0, 32'h7fbf_ffff, 32'h7f80_0001, 0, {2'b11, 32'h7fc0_0001});
    apply("R5 quiet first sig second", 0, 0, 0, 32'h7fc0_0001, 32'h7fbf_ffff, 0, {2'b11, 32'h7fff_ffff});
    apply("R6 raw first NaN", 0, 1, 0, 32'h7fbf_ffff, 32'h7fc0_0001, 0, {2'b10, 32'h7fbf_ffff});
    apply("R6 raw signalling kept", 0, 1, 0, ONE, 32'h7f80_0001, 0, {2'b10, 32'h7f80_0001});
    apply("R7 acc first", 1, 0, 0, 32'h7fc0_0002, ONE, 32'h7fc0_0001, {2'b10, 32'h7fc0_0001});
    apply("R7 m2 over m1", 1, 0, 0, 32'h7fc0_0002, 32'h7fc0_0003, ONE, {2'b10, 32'h7fc0_0003});
    apply("R7 sig m2 quieted", 1, 0, 0, ONE, 32'h7f80_0002, 32'h7fc0_0001, {2'b11, 32'h7fc0_0001});
    apply("R8 m1 first raw", 1, 1, 0, 32'h7fc0_0002, 32'h7fc0_0003, 32'h7fc0_0001, {2'b10, 32'h7fc0_0002});
    apply("R8 m2 over acc", 1, 1, 0, ONE, 32'h7f80_0003, 32'h7fc0_0001, {2'b10, 32'h7f80_0003});
    apply("R8 acc last raw sig", 1, 1, 0, ONE, ONE, 32'h7f80_0001, {2'b10, 32'h7f80_0001});
    apply("R9 default NaN quiet pol", 1, 0, 1, PINF, ZERO, ONE, {2'b11, 32'h7fc0_0000});
    apply("R9 default NaN raw pol", 1, 1, 1, PINF, ZERO, ONE, {2'b10, 32'h7fc0_0000});
    apply("R10 sig acc quieted", 1, 0, 1, PINF, ZERO, 32'h7f80_0001, {2'b11, 32'h7fc0_0001});
    apply("R10 quiet acc flagged", 1, 0, 1, PINF, ZERO, 32'h7fc0_0001, {2'b11, 32'h7fc0_0001});
    apply("R10 raw acc kept", 1, 1, 1, PINF, ZERO, 32'h7f80_0001, {2'b10, 32'h7f80_0001});
    apply("R11 add ignores acc and piz", 0, 0, 1, ONE, ONE, 32'h7f80_0001, 34'h0);
    apply("R11 add ignores acc NaN", 0, 1, 0, ONE, 32'h7fc0_0005, 32'h7f80_0009, {2'b10, 32'h7fc0_0005});
    apply("R12 raw sig no flag", 1, 1, 0, 32'h7f80_0001, 32'h7f80_0002, 32'h7f80_0003, {2'b10, 32'h7f80_0001});
    for (int k = 0; k < 600; k++) begin
      logic [31:0] ra = rand_opnd(), rb = rand_opnd(), rc = rand_opnd();
      bit rf = 1'($urandom), rr = 1'($urandom), rp = 1'($urandom);
      if (rf && rp) begin ra = PINF; rb = ZERO; end
      @(negedge clk);
      fma = rf; rawp = rr; piz = rp; x = ra; y = rb; acc = rc;
      #2;
      check(rr ? "R12 random raw" : "R4 random quieting", ref_model(rf, rr, rp, ra, rb, rc));
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule